// File: doc/BRIEF.md
# Timer Time-Base Counter

This block is the counting core of a general-purpose timer: a 16-bit counter, a prescaler that divides the clock before the counter, and a reload register that sets the counting period. A control word sets the counting shape. In edge-aligned mode the counter counts in one direction. In the three center-aligned modes it counts up and then down. The control word also holds the update gating, the source filter for the update request, single-pulse operation and optional buffering of the reload value.

Every wrap of the counter can produce an update event, and so can a software update-generate command or a slave update pulse. On an update event the buffered prescaler and reload values are copied into the working registers. A separate request output feeds an interrupt or DMA channel. A compare-phase qualifier tells a compare channel whether its flag may set in the present counting phase. Software reaches the block through a register port with a simple write strobe and a registered read.

Top module: `timebase_unit`

## Requirements
- R1: After reset the counter, the prescaler count, the run bit and every control field are 0. The update outputs are low, and the reload preload and reload working values are 16'hFFFF.
- R2: With the run bit (control bit 0) set and prescaler value P (address 1), the counter changes once every P+1 clocks. In edge-aligned up counting (mode bits [6:5]=00, direction bit 4 = 0), once the count is at or above the effective reload value it goes to 0 on the next step and reports a wrap.
- R3: In edge-aligned down counting (direction bit 4 = 1), a step from 0 loads the effective reload value and reports a wrap. Any other step decrements the counter.
- R4: While the update-off bit (control bit 1) is 0, a wrap, a write with control bit 9 set, or a high slave_upd produces a one-clock upd_evt pulse in the following cycle. The same event copies the preloads into the working reload and prescaler values. While the bit is 1, no event occurs and the working values are kept.
- R5: upd_req pulses together with upd_evt. When the request-select bit (control bit 2) is 1, it pulses only for counter wraps.
- R6: With the one-shot bit (control bit 3) set, an update event clears the run bit in the same cycle in which upd_evt rises.
- R7: With the trigger-start bit (control bit 8) set, a high slave_trig sets the run bit on the next clock.
- R8: In center-aligned modes (01, 10, 11), the counter counts up until it reaches the reload value, then counts down to 0, and reports a wrap at both turning points. The direction bit reads back the phase (1 = down). Writes to the direction bit are ignored in these modes, and entering a center mode from edge mode sets the phase to up.
- R9: cmp_ok is high in edge mode and in mode 11. In mode 01 it is high only in the down phase, and in mode 10 only in the up phase.
- R10: A control write leaves the mode field unchanged while the run bit is 1.
- R11: With the reload-buffer bit (control bit 7) at 0, a write to address 2 changes the counting period at once. With the bit at 1, the counter keeps the working value until the next update event.
- R12: An update-generate write or slave_upd resets the prescaler count, and sets the counter to 0, or to the reload preload in edge down counting. It also returns a center mode to the up phase, even while updates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 prescaler, 2 reload, 3 counter |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 16 | Read data, registered one cycle after rd_addr |
| slave_trig | input | 1 | Slave-mode start trigger |
| slave_upd | input | 1 | Slave-mode update and re-initialise |
| upd_evt | output | 1 | Update event pulse |
| upd_req | output | 1 | Update interrupt/DMA request pulse |
| cmp_ok | output | 1 | Compare-flag phase qualifier |
| count | output | 16 | Current counter value |
| running | output | 1 | Run bit |

## Verification
The bench steps through edge up counting with a divided clock, then edge down counting with a short period. The short period shows the difference between a wrap at the reload value and a wrap at zero. Update-generate writes and slave updates are issued with updates on, with updates off and with the request filter set. These cases show the event output and the request output disagreeing. Reload writes with the buffer on and off show the period changing at once or only at the next event. Single-pulse runs, trigger starts and all three center modes check the phase read-back, the qualifier and the ignored direction and mode writes.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  typedef enum logic [1:0] {
    ALIGN_EDGE  = 2'b00,
    ALIGN_C_DN  = 2'b01,
    ALIGN_C_UP  = 2'b10,
    ALIGN_C_ALL = 2'b11
  } align_e;

  localparam int B_RUN   = 0;
  localparam int B_OFF   = 1;
  localparam int B_RSEL  = 2;
  localparam int B_ONES  = 3;
  localparam int B_DIR   = 4;
  localparam int B_MODE  = 5;
  localparam int B_BUF   = 7;
  localparam int B_TRIG  = 8;
  localparam int B_UG    = 9;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PSC  = 2'd1;
  localparam logic [1:0] A_ARR  = 2'd2;
  localparam logic [1:0] A_CNT  = 2'd3;
endpackage

// File: rtl/tmb_prescaler.sv
module tmb_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] preload,
  output logic         tick,
  output logic [W-1:0] pcnt
);
  logic [W-1:0] div_q;

  assign tick = run && (pcnt == div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt  <= '0;
      div_q <= '0;
    end else begin
      if (load) div_q <= preload;
      if (clear)    pcnt <= '0;
      else if (run) pcnt <= tick ? '0 : pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmb_counter.sv
module tmb_counter
  import tmb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  align_e       mode,
  input  logic         tick,
  input  logic         reinit,
  input  logic [W-1:0] reinit_val,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] limit,
  input  logic         phase_clr,
  input  logic         dir_wr,
  input  logic         dir_val,
  output logic [W-1:0] cnt,
  output logic         dir,
  output logic         wrap
);
  logic [W-1:0] nxt_cnt;
  logic         nxt_dir;
  logic         hit;
  logic         center;

  assign center = (mode != ALIGN_EDGE);

  always_comb begin
    nxt_cnt = cnt;
    nxt_dir = dir;
    hit     = 1'b0;
    if (center) begin
      if (!dir) begin
        if (cnt >= limit) begin
          nxt_cnt = (cnt == '0) ? '0 : cnt - 1'b1;
          nxt_dir = 1'b1;
          hit     = 1'b1;
        end else begin
          nxt_cnt = cnt + 1'b1;
        end
      end else if (cnt == '0) begin
        nxt_cnt = (limit == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
        nxt_dir = 1'b0;
        hit     = 1'b1;
      end else begin
        nxt_cnt = cnt - 1'b1;
      end
    end else if (!dir) begin
      if (cnt >= limit) begin
        nxt_cnt = '0;
        hit     = 1'b1;
      end else begin
        nxt_cnt = cnt + 1'b1;
      end
    end else if (cnt == '0) begin
      nxt_cnt = limit;
      hit     = 1'b1;
    end else begin
      nxt_cnt = cnt - 1'b1;
    end
  end

  assign wrap = tick && !reinit && !cnt_wr && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      dir <= 1'b0;
    end else begin
      if (reinit)      cnt <= (!center && dir) ? reinit_val : '0;
      else if (cnt_wr) cnt <= cnt_val;
      else if (tick)   cnt <= nxt_cnt;

      if (phase_clr)                          dir <= 1'b0;
      else if (center && reinit)              dir <= 1'b0;
      else if (center && tick && !cnt_wr)     dir <= nxt_dir;
      else if (dir_wr)                        dir <= dir_val;
    end
  end
endmodule

// File: rtl/tmb_update.sv
module tmb_update (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic sw_gen,
  input  logic slave_upd,
  input  logic upd_off,
  input  logic req_sel,
  output logic reinit,
  output logic uev,
  output logic evt_q,
  output logic req_q
);
  logic req_now;

  assign reinit  = sw_gen || slave_upd;
  assign uev     = !upd_off && (wrap || reinit);
  assign req_now = !upd_off && (wrap || (!req_sel && reinit));

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      evt_q <= uev;
      req_q <= req_now;
    end
  end
endmodule

// File: rtl/timebase_unit.sv
module timebase_unit
  import tmb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         slave_trig,
  input  logic         slave_upd,
  output logic         upd_evt,
  output logic         upd_req,
  output logic         cmp_ok,
  output logic [W-1:0] count,
  output logic         running
);
  localparam logic [W-1:0] ARR_RST = '1;

  logic         run_q, off_q, rsel_q, ones_q, buf_q, trig_q;
  align_e       mode_q, mode_nxt;
  logic [W-1:0] psc_pre, arr_pre, arr_work, arr_eff;
  logic         wr_ctrl, wr_psc, wr_arr, wr_cnt;
  logic         mode_ok, phase_clr, dir_wr;
  logic         tick, wrap, reinit, uev, dir;
  logic [W-1:0] pcnt;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_psc  = wr_en && (wr_addr == A_PSC);
  assign wr_arr  = wr_en && (wr_addr == A_ARR);
  assign wr_cnt  = wr_en && (wr_addr == A_CNT);

  assign mode_ok   = wr_ctrl && !run_q;
  assign mode_nxt  = mode_ok ? align_e'(wr_data[B_MODE +: 2]) : mode_q;
  assign phase_clr = mode_ok && (mode_q == ALIGN_EDGE) && (mode_nxt != ALIGN_EDGE);
  assign dir_wr    = wr_ctrl && (mode_nxt == ALIGN_EDGE);
  assign arr_eff   = buf_q ? arr_work : arr_pre;

  tmb_prescaler #(.W(W)) u_psc (
    .clk(clk), .rst(rst), .run(run_q), .clear(reinit), .load(uev),
    .preload(psc_pre), .tick(tick), .pcnt(pcnt)
  );

  tmb_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .mode(mode_q), .tick(tick), .reinit(reinit),
    .reinit_val(arr_pre), .cnt_wr(wr_cnt), .cnt_val(wr_data), .limit(arr_eff),
    .phase_clr(phase_clr), .dir_wr(dir_wr), .dir_val(wr_data[B_DIR]),
    .cnt(count), .dir(dir), .wrap(wrap)
  );

  tmb_update u_upd (
    .clk(clk), .rst(rst), .wrap(wrap), .sw_gen(wr_ctrl && wr_data[B_UG]),
    .slave_upd(slave_upd), .upd_off(off_q), .req_sel(rsel_q),
    .reinit(reinit), .uev(uev), .evt_q(upd_evt), .req_q(upd_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      off_q    <= 1'b0;
      rsel_q   <= 1'b0;
      ones_q   <= 1'b0;
      buf_q    <= 1'b0;
      trig_q   <= 1'b0;
      mode_q   <= ALIGN_EDGE;
      psc_pre  <= '0;
      arr_pre  <= ARR_RST;
      arr_work <= ARR_RST;
    end else begin
      if (wr_ctrl) begin
        off_q  <= wr_data[B_OFF];
        rsel_q <= wr_data[B_RSEL];
        ones_q <= wr_data[B_ONES];
        buf_q  <= wr_data[B_BUF];
        trig_q <= wr_data[B_TRIG];
      end
      mode_q <= mode_nxt;
      if (uev && ones_q)                run_q <= 1'b0;
      else if (trig_q && slave_trig)    run_q <= 1'b1;
      else if (wr_ctrl)                 run_q <= wr_data[B_RUN];
      if (wr_psc) psc_pre <= wr_data;
      if (wr_arr) arr_pre <= wr_data;
      if (uev)    arr_work <= arr_pre;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        A_CTRL: begin
          rd_data          <= '0;
          rd_data[B_RUN]   <= run_q;
          rd_data[B_OFF]   <= off_q;
          rd_data[B_RSEL]  <= rsel_q;
          rd_data[B_ONES]  <= ones_q;
          rd_data[B_DIR]   <= dir;
          rd_data[B_MODE +: 2] <= mode_q;
          rd_data[B_BUF]   <= buf_q;
          rd_data[B_TRIG]  <= trig_q;
        end
        A_PSC:   rd_data <= psc_pre;
        A_ARR:   rd_data <= arr_pre;
        default: rd_data <= count;
      endcase
    end
  end

  always_comb begin
    unique case (mode_q)
      ALIGN_C_DN: cmp_ok = dir;
      ALIGN_C_UP: cmp_ok = !dir;
      default:    cmp_ok = 1'b1;
    endcase
  end

  assign running = run_q;
endmodule

// File: rtl/tmb_checker.sv
module tmb_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         upd_evt,
  input logic         upd_req,
  input logic         running,
  input logic         off_q,
  input logic         ones_q,
  input logic [1:0]   mode_q,
  input logic         slave_upd,
  input logic [W-1:0] pcnt
);
  p_off_blocks_evt_r4: assert property (@(posedge clk) disable iff (rst)
    $past(off_q) |-> !upd_evt);

  p_req_needs_evt_r5: assert property (@(posedge clk) disable iff (rst)
    upd_req |-> upd_evt);

  p_one_shot_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_evt && $past(ones_q)) |-> !running);

  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    $past(running) |-> $stable(mode_q));

  p_slave_clears_psc_r12: assert property (@(posedge clk) disable iff (rst)
    $past(slave_upd) |-> (pcnt == '0));
endmodule

bind timebase_unit tmb_checker #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .upd_evt(upd_evt), .upd_req(upd_req),
  .running(running), .off_q(off_q), .ones_q(ones_q), .mode_q(mode_q),
  .slave_upd(slave_upd), .pcnt(pcnt)
);

// File: tb/test_timebase_unit.sv
module test_timebase_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic slave_trig = 1'b0;
  logic slave_upd = 1'b0;
  logic upd_evt, upd_req, cmp_ok, running;
  logic [15:0] count;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  timebase_unit i_timebase_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .slave_trig(slave_trig),
    .slave_upd(slave_upd), .upd_evt(upd_evt), .upd_req(upd_req),
    .cmp_ok(cmp_ok), .count(count), .running(running)
  );

  always #5 clk = ~clk;

  // reference model state
  int m_cnt, m_pcnt, m_psc_pre, m_psc_w, m_arr_pre, m_arr_w, m_mode;
  bit m_dir, m_run, m_off, m_rsel, m_os, m_buf, m_trig, m_evt, m_req;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int model_rd(int a);
    if (a == 0) return m_run | (m_off << 1) | (m_rsel << 2) | (m_os << 3) |
                       (m_dir << 4) | (m_mode << 5) | (m_buf << 7) | (m_trig << 8);
    if (a == 1) return m_psc_pre;
    if (a == 2) return m_arr_pre;
    return m_cnt;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = 0; m_pcnt = 0; m_psc_pre = 0; m_psc_w = 0;
      m_arr_pre = 65535; m_arr_w = 65535; m_mode = 0; m_dir = 0;
      m_run = 0; m_off = 0; m_rsel = 0; m_os = 0; m_buf = 0; m_trig = 0;
      m_evt = 0; m_req = 0;
    end else begin
      bit wc, wcnt, reinit, tick, hit, uev, nrun, ndir;
      int arr, ncnt, nmode;
      wc     = wr_en && wr_addr == 0;
      wcnt   = wr_en && wr_addr == 3;
      reinit = (wc && wr_data[9]) || slave_upd;
      arr    = m_buf ? m_arr_w : m_arr_pre;
      tick   = m_run && (m_pcnt == m_psc_w);
      ncnt = m_cnt; ndir = m_dir; hit = 0;
      if (reinit) ncnt = (m_mode == 0 && m_dir) ? m_arr_pre : 0;
      else if (wcnt) ncnt = wr_data;
      else if (tick) begin
        if (m_mode != 0) begin
          if (!m_dir) begin
            if (m_cnt >= arr) begin ncnt = (m_cnt == 0) ? 0 : m_cnt - 1; ndir = 1; hit = 1; end
            else ncnt = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin ncnt = (arr == 0) ? 0 : 1; ndir = 0; hit = 1; end
            else ncnt = m_cnt - 1;
          end
        end else if (!m_dir) begin
          if (m_cnt >= arr) begin ncnt = 0; hit = 1; end else ncnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin ncnt = arr; hit = 1; end else ncnt = m_cnt - 1;
        end
      end
      nmode = (wc && !m_run) ? int'(wr_data[6:5]) : m_mode;
      if (wc && !m_run && m_mode == 0 && nmode != 0) ndir = 0;
      else if (m_mode != 0 && reinit) ndir = 0;
      else if (m_mode != 0 && tick && !wcnt) ; // phase set above
      else if (wc && nmode == 0) ndir = wr_data[4];
      else ndir = m_dir;
      uev = !m_off && (hit || reinit);
      m_req = !m_off && (hit || (!m_rsel && reinit));
      m_evt = uev;
      nrun = wc ? wr_data[0] : m_run;
      if (m_trig && slave_trig) nrun = 1;
      if (uev && m_os) nrun = 0;
      if (reinit) m_pcnt = 0;
      else if (m_run) m_pcnt = tick ? 0 : (m_pcnt + 1) & 16'hFFFF;
      if (uev) begin m_arr_w = m_arr_pre; m_psc_w = m_psc_pre; end
      if (wc) begin
        m_off = wr_data[1]; m_rsel = wr_data[2]; m_os = wr_data[3];
        m_buf = wr_data[7]; m_trig = wr_data[8];
      end
      if (wr_en && wr_addr == 1) m_psc_pre = wr_data;
      if (wr_en && wr_addr == 2) m_arr_pre = wr_data;
      m_cnt = ncnt & 16'hFFFF; m_dir = ndir; m_mode = nmode; m_run = nrun;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit q;
      q = (m_mode == 1) ? m_dir : (m_mode == 2) ? !m_dir : 1'b1;
      chk("R2/R3/R8 count", count, m_cnt);
      chk("R4 upd_evt", upd_evt, m_evt);
      chk("R5 upd_req", upd_req, m_req);
      chk("R6/R7 running", running, m_run);
      chk("R9 cmp_ok", cmp_ok, q);
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] ctl(bit run, bit off, bit rsel, bit os, bit dir,
                                      int mode, bit bufe, bit trig, bit ug);
    return {6'b0, ug, trig, bufe, mode[1:0], dir, os, rsel, off, run};
  endfunction

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(logic [1:0] a, string tag);
    int exp;
    exp = model_rd(a);
    rd_addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse_upd();
    slave_upd = 1; @(negedge clk); slave_upd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 count", count, 0);
    chk("R1 running", running, 0);
    chk("R1 upd_evt", upd_evt, 0);
    rd_addr = 2; @(negedge clk);
    chk("R1 reload preload", rd_data, 65535);
    rd_addr = 0; @(negedge clk);
    chk("R1 control", rd_data, 0);

    // R2: edge up, prescaler 1, reload 4 (unbuffered R11)
    wr(1, 16'd1);
    pulse_upd();              // load prescaler working value (R4, R12)
    wr(2, 16'd4);
    wr(0, ctl(1,0,0,0,0,0,0,0,0));
    idle(30);
    rd_chk(3, "R2 count read");

    // R3: edge down, prescaler 0 via update generate
    wr(1, 16'd0);
    wr(0, ctl(1,0,0,0,1,0,0,0,1));
    idle(15);
    // R11: unbuffered reload change takes effect now
    wr(2, 16'd2);
    idle(10);

    // R4/R12: updates off, update-generate still re-initialises
    wr(0, ctl(1,1,0,0,0,0,0,0,1));
    idle(3);
    wr(0, ctl(1,1,0,0,0,0,0,0,0));
    pulse_upd();
    idle(8);
    // R5: request only on wraps
    wr(0, ctl(1,0,1,0,0,0,0,0,1));
    pulse_upd();
    idle(8);

    // R11: buffered reload
    wr(0, ctl(1,0,0,0,0,0,1,0,0));
    wr(2, 16'd6);
    idle(25);
    rd_chk(2, "R11 reload preload read");

    // R6: one-shot
    wr(0, ctl(1,0,0,1,0,0,1,0,0));
    idle(12);
    chk("R6 stopped", running, 0);

    // R7: trigger start
    wr(0, ctl(0,0,0,0,0,0,0,1,0));
    idle(2);
    slave_trig = 1; @(negedge clk); slave_trig = 0;
    chk("R7 started", running, 1);
    idle(5);

    // R8/R9 center modes 01, 10, 11
    for (int m = 1; m <= 3; m++) begin
      wr(0, ctl(0,0,0,0,1,0,0,0,0));
      wr(2, 16'd5);
      wr(0, ctl(0,0,0,0,1,m,0,0,1));
      rd_chk(0, "R8 enter center phase");
      wr(0, ctl(1,0,0,0,0,m,0,0,0));
      idle(8);
      rd_chk(0, "R8 phase readback");
      wr(0, ctl(1,0,0,0,1,m,0,0,0));   // R8: direction write ignored
      idle(3);
      rd_chk(0, "R8 direction ignored");
      wr(0, ctl(1,0,0,0,0,0,0,0,0));   // R10: mode write ignored
      rd_addr = 0; @(negedge clk);
      chk("R10 mode kept", int'(rd_data[6:5]), m);
      idle(20);
      wr(0, ctl(1,0,0,0,0,m,0,0,1));   // R12: center re-init returns to up
      rd_addr = 0; @(negedge clk);
      chk("R12 phase up after reinit", rd_data[4], 0);
      idle(6);
    end
    wr(0, ctl(0,0,0,0,0,0,0,0,0));
    idle(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule